// File: doc/BRIEF.md
# Prescaled Split-Word Timestamp Counter

This block keeps a free-running 64-bit timestamp. The value is held as two 32-bit words, a low word and a high word, and it advances by one once every four bus clocks. An internal divide-by-four prescaler sets that rate, and an active-high enable gates the prescaler. A carry out of the low word ripples into the high word on the same clock edge. The full count wraps from all ones back to zero.

Software reaches the counter through a single-cycle register port. The port selects one word and carries a privilege bit. Reads are allowed from either privilege level. Writes take effect only from supervisor level. A write from user level leaves the count untouched and raises a one-cycle violation pulse.

To read a 64-bit value that does not tear, software reads the low word first. That read also captures the high word into a shadow register. A later read of the high word returns this shadow, so the two words belong to the same instant even if a carry has happened in between.

Top module: `tstamp_counter`

## Requirements
- R1: After reset the count is zero, `rd_data` is zero, `priv_fault` is low and the high-word shadow is zero.
- R2: With `tick_en` high and no supervisor write, the count increases by exactly one on every fourth rising clock edge and holds on the other three.
- R3: When the low word steps from all ones to zero, the high word increases by one on the same edge. The full 64-bit count steps from all ones to zero.
- R4: While `tick_en` is low, the count and the prescaler phase both hold. Once `tick_en` returns high, counting resumes at the phase where it stopped.
- R5: An access with `acc_req`=1, `acc_wr`=1 and `acc_super`=1 loads `wr_data` into the selected word (`acc_hi`=0 selects the low word, 1 the high word) and leaves the other word unchanged. It also restarts the prescaler, so nothing is added on that edge and the next step comes four enabled edges later.
- R6: An access with `acc_req`=1, `acc_wr`=1 and `acc_super`=0 does not change the count. `priv_fault` is high for exactly the one cycle after that edge.
- R7: A read (`acc_req`=1, `acc_wr`=0) with `acc_hi`=0, at either privilege level, places the low word as it stood before that edge on `rd_data` in the next cycle. The same edge copies the high word into the shadow.
- R8: A read with `acc_hi`=1 returns the shadow captured by the most recent low-word read, not the live high word.
- R9: `rd_data` changes only on a read and holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaler enable |
| acc_req | input | 1 | Register access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_hi | input | 1 | Word select: 0 low word, 1 high word |
| acc_super | input | 1 | 1 = supervisor level, 0 = user level |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| priv_fault | output | 1 | One-cycle pulse after a user-level write |
| count_o | output | 64 | Live 64-bit count |

## Verification
The hard case to reach is a carry from the low word into the high word that falls between the two halves of a split read. The port cannot count through 2^32 steps in a short run, so the stimulus uses supervisor writes to place the low word at all ones and the high word at a small value while the prescaler is stopped. It then reads the low word, enables counting for exactly one prescaler period so the carry happens, and reads the high word. The pre-carry shadow must come back, and a second pair of reads must show the post-carry value. The full wrap is reached the same way by preloading both words just below all ones.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
   typedef enum logic {
      WORD_LO = 1'b0,
      WORD_HI = 1'b1
   } word_sel_e;

   function automatic int unsigned phase_bits(input int unsigned div);
      return (div > 1) ? $clog2(div) : 1;
   endfunction
endpackage

// File: rtl/tstamp_prescale.sv
module tstamp_prescale #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic restart,
   output logic tick
);
   localparam int unsigned PW = tstamp_pkg::phase_bits(DIV);
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   initial begin
      assert (DIV >= 1) else $error("DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_direct
         assign tick = en & ~restart;
      end else begin : g_divided
         logic [PW-1:0] phase_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (restart) begin
               phase_q <= '0;
            end else if (en) begin
               if (phase_q == LAST) phase_q <= '0;
               else                 phase_q <= phase_q + 1'b1;
            end
         end

         assign tick = en & ~restart & (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/tstamp_word.sv
module tstamp_word #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] val,
   output logic         full
);
   initial begin
      assert (W >= 2) else $error("word width too small");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    val <= '0;
      else if (load) val <= load_val;
      else if (step) val <= val + 1'b1;
   end

   assign full = &val;
endmodule

// File: rtl/tstamp_rdport.sv
module tstamp_rdport #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd,
   input  logic         hi,
   input  logic [W-1:0] lo_val,
   input  logic [W-1:0] hi_val,
   output logic [W-1:0] rd_data
);
   logic [W-1:0] shadow_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         rd_data  <= '0;
      end else if (rd) begin
         if (hi == tstamp_pkg::WORD_HI) begin
            rd_data <= shadow_q;
         end else begin
            rd_data  <= lo_val;
            shadow_q <= hi_val;
         end
      end
   end
endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter #(
   parameter int unsigned HALF_W = 32,
   parameter int unsigned DIV    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  logic                acc_req,
   input  logic                acc_wr,
   input  logic                acc_hi,
   input  logic                acc_super,
   input  logic [HALF_W-1:0]   wr_data,
   output logic [HALF_W-1:0]   rd_data,
   output logic                priv_fault,
   output logic [2*HALF_W-1:0] count_o
);
   localparam int unsigned NWORDS = 2;

   logic sup_wr, usr_wr, rd, tick;
   logic [NWORDS-1:0][HALF_W-1:0] word_val;
   logic [NWORDS-1:0]             word_full;

   assign sup_wr = acc_req & acc_wr & acc_super;
   assign usr_wr = acc_req & acc_wr & ~acc_super;
   assign rd     = acc_req & ~acc_wr;

   tstamp_prescale #(.DIV(DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(tick_en), .restart(sup_wr), .tick(tick)
   );

   for (genvar g = 0; g < NWORDS; g++) begin : g_word
      logic ld, stp;
      assign ld = sup_wr & (acc_hi == g[0]);
      if (g == 0) begin : g_lo
         assign stp = tick;
      end else begin : g_hi
         assign stp = tick & word_full[g-1];
      end
      tstamp_word #(.W(HALF_W)) u_word (
         .clk(clk), .rst_n(rst_n), .load(ld), .load_val(wr_data),
         .step(stp), .val(word_val[g]), .full(word_full[g])
      );
   end

   tstamp_rdport #(.W(HALF_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd(rd), .hi(acc_hi),
      .lo_val(word_val[0]), .hi_val(word_val[1]), .rd_data(rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) priv_fault <= 1'b0;
      else        priv_fault <= usr_wr;
   end

   assign count_o = {word_val[1], word_val[0]};
endmodule

// File: rtl/tstamp_counter_chk.sv
module tstamp_counter_chk #(
   parameter int unsigned HALF_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick_en,
   input logic                acc_req,
   input logic                acc_wr,
   input logic                acc_super,
   input logic [HALF_W-1:0]   rd_data,
   input logic                priv_fault,
   input logic [2*HALF_W-1:0] count_o
);
   logic sup_wr, usr_wr;
   assign sup_wr = acc_req & acc_wr & acc_super;
   assign usr_wr = acc_req & acc_wr & ~acc_super;

   // R2: without a supervisor write the count holds or steps by one
   p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_wr |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));

   // R3: a low-word rollover carries into the high word
   p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sup_wr && tick_en && (&count_o[HALF_W-1:0])) |=>
         (count_o[HALF_W-1:0] == '0) ?
            (count_o[2*HALF_W-1:HALF_W] == $past(count_o[2*HALF_W-1:HALF_W]) + 1'b1) : 1'b1);

   // R4: no movement while the prescaler is gated
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !sup_wr) |=> $stable(count_o));

   // R6: violation pulse follows a user write and lasts one cycle
   p_fault_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      usr_wr |=> priv_fault);
   p_fault_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !usr_wr |=> !priv_fault);

   // R9: read data holds between reads
   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_req && !acc_wr) |=> $stable(rd_data));
endmodule

bind tstamp_counter tstamp_counter_chk #(.HALF_W(HALF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .acc_req(acc_req),
   .acc_wr(acc_wr), .acc_super(acc_super), .rd_data(rd_data),
   .priv_fault(priv_fault), .count_o(count_o)
);

// File: tb/tstamp_counter_test.sv
`timescale 1ns/1ps
module tstamp_counter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        acc_req = 1'b0, acc_wr = 1'b0, acc_hi = 1'b0, acc_super = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        priv_fault;
   logic [63:0] count_o;

   int tests = 0, fails = 0;
   bit done = 0;

   // behavioural reference state
   logic [63:0] m_cnt = '0;
   int          m_phase = 0;
   logic [31:0] m_shadow = '0, m_rd = '0;
   logic        m_fault = 1'b0;

   always #4 clk = ~clk;

   tstamp_counter uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .acc_req(acc_req),
      .acc_wr(acc_wr), .acc_hi(acc_hi), .acc_super(acc_super),
      .wr_data(wr_data), .rd_data(rd_data), .priv_fault(priv_fault),
      .count_o(count_o)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_phase = 0; m_shadow = '0; m_rd = '0; m_fault = 1'b0;
      end else begin
         m_fault = acc_req && acc_wr && !acc_super;
         if (acc_req && !acc_wr) begin
            if (acc_hi) m_rd = m_shadow;
            else begin m_rd = m_cnt[31:0]; m_shadow = m_cnt[63:32]; end
         end
         if (acc_req && acc_wr && acc_super) begin
            if (acc_hi) m_cnt[63:32] = wr_data;
            else        m_cnt[31:0]  = wr_data;
            m_phase = 0;
         end else if (tick_en) begin
            if (m_phase == 3) begin m_cnt = m_cnt + 64'd1; m_phase = 0; end
            else m_phase = m_phase + 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 count vs model", count_o, m_cnt);
         chk("R9 rd_data vs model", {32'd0, rd_data}, {32'd0, m_rd});
         chk("R6 priv_fault vs model", {63'd0, priv_fault}, {63'd0, m_fault});
      end
   end

   task automatic access(input logic w, input logic hi, input logic sup, input logic [31:0] d);
      acc_req = 1'b1; acc_wr = w; acc_hi = hi; acc_super = sup; wr_data = d;
      @(negedge clk);
      acc_req = 1'b0; acc_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset count", count_o, 64'd0);
      chk("R1 reset rd_data", {32'd0, rd_data}, 64'd0);
      chk("R1 reset priv_fault", {63'd0, priv_fault}, 64'd0);
      access(1'b0, 1'b1, 1'b0, '0);
      chk("R1 shadow zero after reset", {32'd0, rd_data}, 64'd0);

      // R2: free counting
      tick_en = 1'b1;
      repeat (4) @(negedge clk);
      held = count_o;
      repeat (4) @(negedge clk);
      chk("R2 one step per four clocks", count_o, held + 64'd1);
      repeat (37) @(negedge clk);

      // R4: gated hold, then resume
      tick_en = 1'b0;
      held = count_o;
      repeat (10) @(negedge clk);
      chk("R4 hold while disabled", count_o, held);
      tick_en = 1'b1;
      repeat (9) @(negedge clk);

      // R6: user writes have no effect
      held = count_o;
      tick_en = 1'b0;
      access(1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF);
      chk("R6 user write pulse", {63'd0, priv_fault}, 64'd1);
      chk("R6 user write no change", count_o, held);
      @(negedge clk);
      chk("R6 pulse one cycle", {63'd0, priv_fault}, 64'd0);
      access(1'b1, 1'b1, 1'b0, 32'h1234_5678);
      chk("R6 user write high no change", count_o, held);

      // R5: supervisor loads, other word intact, prescaler restart
      access(1'b1, 1'b1, 1'b1, 32'h0000_00A0);
      chk("R5 load high word", count_o, {32'h0000_00A0, held[31:0]});
      access(1'b1, 1'b0, 1'b1, 32'h0000_0010);
      chk("R5 load low word", count_o, 64'h0000_00A0_0000_0010);
      tick_en = 1'b1;
      repeat (3) @(negedge clk);
      chk("R5 no step before restart period", count_o, 64'h0000_00A0_0000_0010);
      @(negedge clk);
      chk("R5 step after restart period", count_o, 64'h0000_00A0_0000_0011);

      // R7, R8: split read across a carry
      tick_en = 1'b0;
      access(1'b1, 1'b1, 1'b1, 32'h0000_0005);
      access(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF);
      access(1'b0, 1'b0, 1'b0, '0);
      chk("R7 low read", {32'd0, rd_data}, 64'h0000_0000_FFFF_FFFF);
      tick_en = 1'b1;
      repeat (4) @(negedge clk);
      tick_en = 1'b0;
      chk("R3 carry into high word", count_o, 64'h0000_0006_0000_0000);
      access(1'b0, 1'b1, 1'b0, '0);
      chk("R8 high read returns shadow", {32'd0, rd_data}, 64'h5);
      access(1'b0, 1'b0, 1'b1, '0);
      chk("R7 low read after carry", {32'd0, rd_data}, 64'h0);
      access(1'b0, 1'b1, 1'b1, '0);
      chk("R8 high read new shadow", {32'd0, rd_data}, 64'h6);
      repeat (3) @(negedge clk);
      chk("R9 rd_data holds", {32'd0, rd_data}, 64'h6);

      // R3: full wrap
      access(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF);
      access(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFD);
      tick_en = 1'b1;
      repeat (12) @(negedge clk);
      chk("R3 full wrap to zero", count_o, 64'd0);
      repeat (8) @(negedge clk);
      chk("R2 counting after wrap", count_o, 64'd2);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule